// File: doc/BRIEF.md
# Output Port Function Selector

This block drives an eight-pin output port for a dual serial-channel peripheral. Each pin either reflects one bit of a general-purpose output register or is switched by a control register to an internal signal. The switchable signals are request-to-send for two channels, the channel bit clocks, the counter/timer output, and the receiver and transmitter readiness flags. Their sources arrive as inputs from the channel and timer logic. Open-drain pins are modelled as a value plus an output enable.

Request-to-send lives in output register bits 0 and 1. It can be dropped automatically in two ways: a channel's transmitter can clear the request when it drains, and a channel's receiver can hold the pin inactive while its queue is full. All pins come out of flops. A control change therefore moves only the pin it selects, one clock after the write. Pins whose selection is unchanged keep their value.

Top module: `opsel_port`

## Requirements
- R1: While reset is asserted, the output register and the control register are cleared and all eight pins drive high (pin_o = 8'hFF, pin_oe = 8'hFF).
- R2: A pin in general-purpose mode drives the inverse of its output register bit, with the output enable on. A register write at clock edge k appears on the pin at edge k+1.
- R3: When receive-side auto request is enabled for a channel (control bit 10 for channel A on pin 0, bit 11 for channel B on pin 1) and that channel's queue-full input is high, the pin is forced high. Otherwise pin 0 or 1 follows R2.
- R4: When transmit-side auto request is enabled (control bit 8 for channel A, bit 9 for channel B) and the channel's transmitter-empty input rises from low to high, output register bit 0 or 1 is cleared at that edge. A steady high level clears nothing.
- R5: Control bits [1:0] select pin 2: 0 general purpose, 1 channel A transmit 16X clock, 2 channel A transmit 1X clock, 3 channel A receive 1X clock.
- R6: Control bits [3:2] select pin 3: 0 general purpose, 1 counter/timer output (open drain, active when ct_out is high), 2 channel B transmit 1X clock, 3 channel B receive 1X clock.
- R7: Control bits 4 and 5 switch pins 4 and 5 to open-drain receive flags for channels A and B. Control bit 12 (channel A) and bit 13 (channel B) pick the queue-full input instead of the receiver-ready input.
- R8: Control bits 6 and 7 switch pins 6 and 7 to open-drain transmitter-ready flags for channels A and B.
- R9: An open-drain function drives low with the output enable on when its signal is active. When the signal is inactive it releases the pin: output enable off, value high.
- R10: A control write at edge k changes the selected pin at edge k+1. Pins whose selection did not change keep their value.
- R11: An output register write in the same cycle as a transmit-side auto clear takes priority, so the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opr_wr | input | 1 | Output register write strobe |
| opr_wdata | input | 8 | Output register write value |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 14 | Control register write value |
| a_txc16 | input | 1 | Channel A transmit 16X clock |
| ch_txc1 | input | 2 | Transmit 1X clock per channel (bit 0 = A) |
| ch_rxc1 | input | 2 | Receive 1X clock per channel |
| ch_rx_rdy | input | 2 | Receiver has data, per channel |
| ch_rx_full | input | 2 | Receive queue full, per channel |
| ch_tx_rdy | input | 2 | Transmit holding register free, per channel |
| ch_tx_empty | input | 2 | Transmit shift and holding registers both empty |
| ct_out | input | 1 | Counter/timer output, high when active |
| pin_o | output | 8 | Pin values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The assertions assume the control and data inputs are synchronous to clk and that strobes stay low while reset is held. They also assume the default parameter set, where released open-drain pins turn their enable off. The stimulus changes every input only at the falling edge and keeps all strobes low during reset. Writes and transmitter-empty edges are drawn at moderate rates, so auto-clear events, write collisions and selection changes all occur many times. Directed sequences then force the same-cycle write collision and a single-field control change with all other inputs held still.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
   localparam int PORT_W    = 8;
   localparam int CH_N      = 2;
   localparam int CTL_W     = 14;
   localparam int F_P2SEL   = 0;
   localparam int F_P3SEL   = 2;
   localparam int F_FNEN    = 4;
   localparam int F_TXAUTO  = 8;
   localparam int F_RXAUTO  = 10;
   localparam int F_FULLSEL = 12;

   typedef enum logic [1:0] {P2_GP, P2_TXC16, P2_TXC1, P2_RXC1} p2_sel_e;
   typedef enum logic [1:0] {P3_GP, P3_TIMER, P3_TXC1, P3_RXC1} p3_sel_e;

   typedef struct packed {
      logic o;
      logic oe;
   } pin_drv_t;
endpackage

// File: rtl/opsel_rts.sv
module opsel_rts #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tx_empty,
   input  logic [NUM_CH-1:0] tx_auto,
   input  logic              opr_wr,
   output logic [NUM_CH-1:0] clr_req
);
   logic [NUM_CH-1:0] empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) empty_q <= '1;
      else        empty_q <= tx_empty;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign clr_req[c] = tx_auto[c] & tx_empty[c] & ~empty_q[c] & ~opr_wr;
   end

   // R4: a clear request only follows a low sample of the empty flag
   p_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_req) |-> (|(~empty_q & clr_req)));
endmodule

// File: rtl/opsel_regs.sv
module opsel_regs #(
   parameter int NUM_PINS = 8,
   parameter int CTL_W    = 14,
   parameter int NUM_CH   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                opr_wr,
   input  logic [NUM_PINS-1:0] opr_wdata,
   input  logic                ctl_wr,
   input  logic [CTL_W-1:0]    ctl_wdata,
   input  logic [NUM_CH-1:0]   clr_req,
   output logic [NUM_PINS-1:0] opr_q,
   output logic [CTL_W-1:0]    ctl_q
);
   logic [NUM_PINS-1:0] clr_mask;
   logic [NUM_PINS-1:0] opr_nxt;

   always_comb begin
      clr_mask = '0;
      clr_mask[NUM_CH-1:0] = clr_req;
      opr_nxt = opr_wr ? opr_wdata : (opr_q & ~clr_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opr_q <= '0;
         ctl_q <= '0;
      end else begin
         opr_q <= opr_nxt;
         if (ctl_wr) ctl_q <= ctl_wdata;
      end
   end

   // R11: a write always lands, auto clear or not
   p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(opr_wr)) |-> (opr_q == $past(opr_wdata)));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R4: a requested clear leaves the request bit low
      p_auto_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(clr_req[c])) |-> !opr_q[c]);
   end
endmodule

// File: rtl/opsel_pinmux.sv
module opsel_pinmux
   import opsel_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int NUM_CH   = 2,
   parameter bit OD_AS_OE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] opr_q,
   input  logic [1:0]          sel2,
   input  logic [1:0]          sel3,
   input  logic [3:0]          fn_en,
   input  logic [NUM_CH-1:0]   rx_auto,
   input  logic [NUM_CH-1:0]   full_sel,
   input  logic                a_txc16,
   input  logic [NUM_CH-1:0]   ch_txc1,
   input  logic [NUM_CH-1:0]   ch_rxc1,
   input  logic [NUM_CH-1:0]   ch_rx_rdy,
   input  logic [NUM_CH-1:0]   ch_rx_full,
   input  logic [NUM_CH-1:0]   ch_tx_rdy,
   input  logic                ct_out,
   output logic [NUM_PINS-1:0] pin_o,
   output logic [NUM_PINS-1:0] pin_oe
);
   logic rel_oe;

   if (OD_AS_OE) begin : g_od_release
      assign rel_oe = 1'b0;
   end else begin : g_od_push
      assign rel_oe = 1'b1;
   end

   function automatic pin_drv_t od_drv(input logic act, input logic roe);
      pin_drv_t d;
      d.o  = ~act;
      d.oe = act | roe;
      return d;
   endfunction

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pin_drv_t nxt;
      pin_drv_t gp;

      assign gp = '{o: ~opr_q[i], oe: 1'b1};

      if (i < NUM_CH) begin : g_rts
         always_comb begin
            nxt = gp;
            if (rx_auto[i] && ch_rx_full[i]) nxt.o = 1'b1;
         end
         // R3: full queue with receive auto holds request inactive
         p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rx_auto[i] & ch_rx_full[i])) |-> pin_o[i]);
      end else if (i == 2) begin : g_p2
         always_comb begin
            nxt = '{o: 1'b1, oe: 1'b1};
            case (p2_sel_e'(sel2))
               P2_GP:    nxt = gp;
               P2_TXC16: nxt.o = a_txc16;
               P2_TXC1:  nxt.o = ch_txc1[0];
               P2_RXC1:  nxt.o = ch_rxc1[0];
               default:  nxt = gp;
            endcase
         end
      end else if (i == 3) begin : g_p3
         always_comb begin
            nxt = '{o: 1'b1, oe: 1'b1};
            case (p3_sel_e'(sel3))
               P3_GP:    nxt = gp;
               P3_TIMER: nxt = od_drv(ct_out, rel_oe);
               P3_TXC1:  nxt.o = ch_txc1[1];
               P3_RXC1:  nxt.o = ch_rxc1[1];
               default:  nxt = gp;
            endcase
         end
      end else if (i < 6) begin : g_rxf
         localparam int CH = i - 4;
         logic flag;
         assign flag = full_sel[CH] ? ch_rx_full[CH] : ch_rx_rdy[CH];
         assign nxt  = fn_en[i-4] ? od_drv(flag, rel_oe) : gp;
         // R2: general-purpose pins show the inverted register bit
         p_gp_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(fn_en[i-4])) |-> (pin_o[i] == !$past(opr_q[i]) && pin_oe[i]));
      end else begin : g_txf
         localparam int CH = i - 6;
         assign nxt = fn_en[i-4] ? od_drv(ch_tx_rdy[CH], rel_oe) : gp;
         // R8: ready transmitter pulls its pin low
         p_txrdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(fn_en[i-4] & ch_tx_rdy[CH])) |-> (!pin_o[i] && pin_oe[i]));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_o[i]  <= 1'b1;
            pin_oe[i] <= 1'b1;
         end else begin
            pin_o[i]  <= nxt.o;
            pin_oe[i] <= nxt.oe;
         end
      end

      if (OD_AS_OE) begin : g_od_chk
         // R9: a released pin never drives low
         p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_oe[i] |-> pin_o[i]);
      end
   end
endmodule

// File: rtl/opsel_port.sv
module opsel_port
   import opsel_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int NUM_CH   = 2,
   parameter bit OD_AS_OE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                opr_wr,
   input  logic [NUM_PINS-1:0] opr_wdata,
   input  logic                ctl_wr,
   input  logic [CTL_W-1:0]    ctl_wdata,
   input  logic                a_txc16,
   input  logic [NUM_CH-1:0]   ch_txc1,
   input  logic [NUM_CH-1:0]   ch_rxc1,
   input  logic [NUM_CH-1:0]   ch_rx_rdy,
   input  logic [NUM_CH-1:0]   ch_rx_full,
   input  logic [NUM_CH-1:0]   ch_tx_rdy,
   input  logic [NUM_CH-1:0]   ch_tx_empty,
   input  logic                ct_out,
   output logic [NUM_PINS-1:0] pin_o,
   output logic [NUM_PINS-1:0] pin_oe
);
   if (NUM_PINS != PORT_W) begin : g_bad_pins
      $error("opsel_port: pin map is fixed at %0d pins", PORT_W);
   end
   if (NUM_CH != CH_N) begin : g_bad_ch
      $error("opsel_port: pin map is fixed at %0d channels", CH_N);
   end

   logic [NUM_PINS-1:0] opr_q;
   logic [CTL_W-1:0]    ctl_q;
   logic [NUM_CH-1:0]   clr_req;

   opsel_rts #(.NUM_CH(NUM_CH)) u_rts (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_empty (ch_tx_empty),
      .tx_auto  (ctl_q[F_TXAUTO +: NUM_CH]),
      .opr_wr   (opr_wr),
      .clr_req  (clr_req)
   );

   opsel_regs #(.NUM_PINS(NUM_PINS), .CTL_W(CTL_W), .NUM_CH(NUM_CH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .opr_wr    (opr_wr),
      .opr_wdata (opr_wdata),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .clr_req   (clr_req),
      .opr_q     (opr_q),
      .ctl_q     (ctl_q)
   );

   opsel_pinmux #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH), .OD_AS_OE(OD_AS_OE)) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .opr_q      (opr_q),
      .sel2       (ctl_q[F_P2SEL +: 2]),
      .sel3       (ctl_q[F_P3SEL +: 2]),
      .fn_en      (ctl_q[F_FNEN +: 4]),
      .rx_auto    (ctl_q[F_RXAUTO +: NUM_CH]),
      .full_sel   (ctl_q[F_FULLSEL +: NUM_CH]),
      .a_txc16    (a_txc16),
      .ch_txc1    (ch_txc1),
      .ch_rxc1    (ch_rxc1),
      .ch_rx_rdy  (ch_rx_rdy),
      .ch_rx_full (ch_rx_full),
      .ch_tx_rdy  (ch_tx_rdy),
      .ct_out     (ct_out),
      .pin_o      (pin_o),
      .pin_oe     (pin_oe)
   );

   // R10: with no control write and still inputs, pins 4..7 hold
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ctl_wr && !opr_wr) && $stable(ctl_q) && $stable(opr_q)
       && $stable(ch_rx_rdy) && $stable(ch_rx_full) && $stable(ch_tx_rdy)
       && $past(rst_n, 2))
      |=> (pin_o[7:4] == $past(pin_o[7:4])));
endmodule

// File: tb/opsel_port_tb.sv
`timescale 1ns/1ps
module opsel_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        opr_wr = 1'b0;
   logic [7:0]  opr_wdata = '0;
   logic        ctl_wr = 1'b0;
   logic [13:0] ctl_wdata = '0;
   logic        a_txc16 = 1'b0;
   logic [1:0]  ch_txc1 = '0, ch_rxc1 = '0, ch_rx_rdy = '0, ch_rx_full = '0;
   logic [1:0]  ch_tx_rdy = '0, ch_tx_empty = '0;
   logic        ct_out = 1'b0;
   logic [7:0]  pin_o, pin_oe;

   int    n_chk = 0, n_fail = 0;
   bit    done = 0;
   logic [7:0]  m_opr;
   logic [13:0] m_ctl;
   logic [1:0]  m_prev;
   logic [7:0]  e_o, e_oe;
   string       e_tag [8];

   always #4 clk = ~clk;

   opsel_port u_dut (
      .clk(clk), .rst_n(rst_n), .opr_wr(opr_wr), .opr_wdata(opr_wdata),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .a_txc16(a_txc16),
      .ch_txc1(ch_txc1), .ch_rxc1(ch_rxc1), .ch_rx_rdy(ch_rx_rdy),
      .ch_rx_full(ch_rx_full), .ch_tx_rdy(ch_tx_rdy), .ch_tx_empty(ch_tx_empty),
      .ct_out(ct_out), .pin_o(pin_o), .pin_oe(pin_oe));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // expected {value, enable} for one pin from the requirements
   function automatic logic [1:0] exp_pin(input int i);
      logic [1:0] gp;
      gp = {~m_opr[i], 1'b1};
      case (i)
         0, 1: return {(m_ctl[10+i] & ch_rx_full[i]) | ~m_opr[i], 1'b1};     // R3
         2: case (m_ctl[1:0])                                                  // R5
               2'd0: return gp;
               2'd1: return {a_txc16, 1'b1};
               2'd2: return {ch_txc1[0], 1'b1};
               default: return {ch_rxc1[0], 1'b1};
            endcase
         3: case (m_ctl[3:2])                                                  // R6
               2'd0: return gp;
               2'd1: return {~ct_out, ct_out};
               2'd2: return {ch_txc1[1], 1'b1};
               default: return {ch_rxc1[1], 1'b1};
            endcase
         4, 5: begin                                                          // R7
            logic f;
            f = m_ctl[12+i-4] ? ch_rx_full[i-4] : ch_rx_rdy[i-4];
            return m_ctl[i] ? {~f, f} : gp;
         end
         default: return m_ctl[i] ? {~ch_tx_rdy[i-6], ch_tx_rdy[i-6]} : gp;  // R8
      endcase
   endfunction

   function automatic string tag_of(input int i);
      if (i < 2) return m_ctl[8+i] ? "R4" : (m_ctl[10+i] ? "R3" : "R2");
      if (i == 2) return (m_ctl[1:0] == 0) ? "R2" : "R5";
      if (i == 3) return (m_ctl[3:2] == 0) ? "R2" : "R6";
      if (!m_ctl[i]) return "R2";
      return (i < 6) ? "R7" : "R8";
   endfunction

   // advance the model across the coming rising edge
   task automatic model();
      logic [1:0] clr;
      for (int i = 0; i < 8; i++) begin
         logic [1:0] d;
         d = exp_pin(i);
         e_o[i] = d[1];
         e_oe[i] = d[0];
         e_tag[i] = tag_of(i);
      end
      for (int c = 0; c < 2; c++)
         clr[c] = m_ctl[8+c] & ch_tx_empty[c] & ~m_prev[c] & ~opr_wr;
      m_opr  = opr_wr ? opr_wdata : (m_opr & ~{6'b0, clr});
      if (ctl_wr) m_ctl = ctl_wdata;
      m_prev = ch_tx_empty;
   endtask

   task automatic sample();
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         check(e_tag[i], {7'b0, pin_o[i]}, {7'b0, e_o[i]});
         check((e_tag[i] == "R2") ? "R2" : "R9", {7'b0, pin_oe[i]}, {7'b0, e_oe[i]});
      end
   endtask

   task automatic quiet();
      opr_wr = 0; ctl_wr = 0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C7A));
      m_opr = '0; m_ctl = '0; m_prev = 2'b11;
      e_o = '1; e_oe = '1;
      for (int i = 0; i < 8; i++) e_tag[i] = "R1";
      ch_tx_empty = 2'b11;
      repeat (3) @(negedge clk);
      check("R1", pin_o, 8'hFF);
      check("R1", pin_oe, 8'hFF);
      rst_n = 1'b1;
      sample();

      // directed R11: auto clear collides with a write of the same bit
      opr_wdata = 8'h01; opr_wr = 1; ctl_wdata = 14'h0100; ctl_wr = 1;
      ch_tx_empty = 2'b00; model(); sample();
      quiet(); model(); sample();
      ch_tx_empty = 2'b01; opr_wr = 1; opr_wdata = 8'h01; model(); sample();
      quiet(); model(); sample();
      check("R11", {7'b0, pin_o[0]}, 8'h00);
      // directed R4: a later rising edge with no write clears the request
      ch_tx_empty = 2'b00; model(); sample();
      ch_tx_empty = 2'b01; model(); sample();
      model(); sample();
      check("R4", {7'b0, pin_o[0]}, 8'h01);

      // directed R10: change only pin 2 select, others must hold
      begin
         logic [7:0] snap_o, snap_oe;
         ctl_wdata = 14'h30F0; ctl_wr = 1; opr_wdata = 8'h5A; opr_wr = 1;
         ch_rx_rdy = 2'b01; ch_tx_rdy = 2'b10; ch_rx_full = 2'b10; ct_out = 1; a_txc16 = 1;
         model(); sample();
         quiet(); model(); sample();
         snap_o = pin_o; snap_oe = pin_oe;
         ctl_wdata = 14'h30F1; ctl_wr = 1; model(); sample();
         check("R10", {7'b0, pin_o[2]}, {7'b0, snap_o[2]});
         quiet(); model(); sample();
         check("R10", pin_o & 8'hFB, snap_o & 8'hFB);
         check("R10", pin_oe, snap_oe);
         check("R5", {7'b0, pin_o[2]}, 8'h01);
      end

      // random mix
      for (int n = 0; n < 4000; n++) begin
         opr_wr = ($urandom % 6) == 0;
         opr_wdata = 8'($urandom);
         ctl_wr = ($urandom % 10) == 0;
         ctl_wdata = 14'($urandom);
         a_txc16 = 1'($urandom);
         ch_txc1 = 2'($urandom); ch_rxc1 = 2'($urandom);
         ch_rx_rdy = 2'($urandom); ch_rx_full = 2'($urandom);
         ch_tx_rdy = 2'($urandom); ct_out = 1'($urandom);
         if (($urandom % 3) == 0) ch_tx_empty = 2'($urandom);
         model(); sample();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule